// File: doc/BRIEF.md
# DMA Bus Cycle State Sequencer

This block steps one DMA service through its bus cycles, one clock per state. From idle it picks up a service request and raises the hold request. It then waits in S0 for the hold acknowledge. After that it runs the working states that drive the memory and I/O strobes. Between device and memory, the controller asserts one memory strobe and one I/O strobe together, so the data moves directly and never passes through the controller. A memory-to-memory service uses a separate eight-state path: a read half followed by a write half.

Two things are fixed when the sequencer leaves idle: the timing flavour (normal or compressed) and the transfer kind. At the last working state, the end-of-service input decides between two outcomes. Either the sequencer drops the hold and returns to idle, or it starts the next transfer of the same service. Channel arbitration, the address and count registers, and the programming interface are out of scope.

Top module: `dma_cycle_seq`

## Requirements
- R1: A synchronous active-high reset forces IDLE, with `hold_req` low and all four strobes low.
- R2: `svc_req` is sampled on the falling clock edge. In IDLE, a sampled request moves the sequencer to S0 on the next rising edge. A pulse that does not span a falling edge is not seen.
- R3: S0 is held until `hold_ack` is high, and then the sequencer advances. `hold_req` is high in every state except IDLE, and it stays low in IDLE after a service ends.
- R4: Normal timing follows S1, S2, S3. S3 moves to SW when `ready` is low and to S4 when it is high. SW repeats while `ready` is low and moves to S4 on the first cycle `ready` is high.
- R5: Compressed timing skips S3. S2 moves to S4 when `ready` is high, or to SW when it is low. SW exits to S4 as in R4.
- R6: For device/memory transfers, strobes are active in S2, S3, SW and S4 in normal timing, and only in S2 and SW in compressed timing. The active pair is `io_rd`+`mem_wr` when direction is 1 (device to memory), and `mem_rd`+`io_wr` when direction is 0. No strobe is active in IDLE, S0 or S1.
- R7: When the memory-to-memory flag is set, S0 leads to M11, M12, M13, M14, M21, M22, M23, M24 in turn, with `ready` ignored. `mem_rd` is active in M12 and M13 only, `mem_wr` is active in M22 and M23 only, and the I/O strobes stay low.
- R8: In S4 or M24, `end_svc` high leads to IDLE. When it is low, the next state is S1 (or M11 for memory-to-memory). `end_svc` has no effect in any other state.
- R9: The compressed, memory-to-memory and direction inputs are captured when IDLE is left. Changes to them during a service have no effect.
- R10: `state_code` encodes IDLE=0, S0=1, S1=2, S2=3, S3=4, SW=5, S4=6, and M11..M14=7..10, M21..M24=11..14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_req | input | 1 | Service request, sampled on the falling edge |
| hold_ack | input | 1 | Bus hold acknowledge |
| ready | input | 1 | Slow-device ready; low inserts wait states |
| compressed | input | 1 | Compressed timing select |
| mem2mem | input | 1 | Memory-to-memory transfer select |
| dev_to_mem | input | 1 | Direction: 1 device to memory, 0 memory to device |
| end_svc | input | 1 | End of service, looked at in S4 and M24 |
| hold_req | output | 1 | Bus hold request |
| state_code | output | 4 | Current state, encoded as in R10 |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The sequencer is driven cycle by cycle through three services. The first is a normal-timing device-to-memory transfer with one wait state after S3. The second is a compressed-timing memory-to-device transfer: it runs once with no wait and once with a wait, and its mode inputs are flipped mid-service, which separates the S2 exit point from the S3 exit point and shows that the captured modes are held. The third is a memory-to-memory run with `ready` held low and `end_svc` raised one state early, which shows that `ready` is ignored on that path, that `end_svc` is honoured only in M24, and that the service continues at M11. Directed cases cover reset in mid-service and a request pulse that misses the falling edge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 4'd0,
        ST_S0   = 4'd1,
        ST_S1   = 4'd2,
        ST_S2   = 4'd3,
        ST_S3   = 4'd4,
        ST_SW   = 4'd5,
        ST_S4   = 4'd6,
        ST_M11  = 4'd7,
        ST_M12  = 4'd8,
        ST_M13  = 4'd9,
        ST_M14  = 4'd10,
        ST_M21  = 4'd11,
        ST_M22  = 4'd12,
        ST_M23  = 4'd13,
        ST_M24  = 4'd14
    } seq_state_e;

endpackage

// File: rtl/dma_seq_next.sv
module dma_seq_next
    import dma_seq_pkg::*;
(
    input  seq_state_e cur,
    input  logic       req_seen,
    input  logic       hold_ack,
    input  logic       ready,
    input  logic       cmp_mode,
    input  logic       m2m_mode,
    input  logic       end_svc,
    output seq_state_e nxt
);

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_IDLE: nxt = req_seen ? ST_S0 : ST_IDLE;
            ST_S0: begin
                if (hold_ack) nxt = m2m_mode ? ST_M11 : ST_S1;
                else          nxt = ST_S0;
            end
            ST_S1: nxt = ST_S2;
            ST_S2: begin
                if (cmp_mode) nxt = ready ? ST_S4 : ST_SW;
                else          nxt = ST_S3;
            end
            ST_S3:  nxt = ready ? ST_S4 : ST_SW;
            ST_SW:  nxt = ready ? ST_S4 : ST_SW;
            ST_S4:  nxt = end_svc ? ST_IDLE : ST_S1;
            ST_M11: nxt = ST_M12;
            ST_M12: nxt = ST_M13;
            ST_M13: nxt = ST_M14;
            ST_M14: nxt = ST_M21;
            ST_M21: nxt = ST_M22;
            ST_M22: nxt = ST_M23;
            ST_M23: nxt = ST_M24;
            ST_M24: nxt = end_svc ? ST_IDLE : ST_M11;
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
    import dma_seq_pkg::*;
(
    input  seq_state_e cur,
    input  logic       cmp_mode,
    input  logic       dir_mode,
    output logic       hold_req,
    output logic       io_rd,
    output logic       io_wr,
    output logic       mem_rd,
    output logic       mem_wr
);

    logic xfer_on;

    always_comb begin
        hold_req = (cur != ST_IDLE);
        xfer_on  = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        unique case (cur)
            ST_S2, ST_SW:   xfer_on = 1'b1;
            ST_S3, ST_S4:   xfer_on = !cmp_mode;
            ST_M12, ST_M13: mem_rd  = 1'b1;
            ST_M22, ST_M23: mem_wr  = 1'b1;
            default:        xfer_on = 1'b0;
        endcase
        if (xfer_on) begin
            if (dir_mode) begin
                io_rd  = 1'b1;
                mem_wr = 1'b1;
            end else begin
                mem_rd = 1'b1;
                io_wr  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               svc_req,
    input  logic               hold_ack,
    input  logic               ready,
    input  logic               compressed,
    input  logic               mem2mem,
    input  logic               dev_to_mem,
    input  logic               end_svc,
    output logic               hold_req,
    output logic [STATE_W-1:0] state_code,
    output logic               io_rd,
    output logic               io_wr,
    output logic               mem_rd,
    output logic               mem_wr
);

    seq_state_e state, state_nxt;
    logic       req_seen;
    logic       cmp_q, m2m_q, dir_q;

    // request line captured on the falling edge
    always_ff @(negedge clk) begin
        if (rst) req_seen <= 1'b0;
        else     req_seen <= svc_req;
    end

    // state register and mode capture on leaving idle
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmp_q <= 1'b0;
            m2m_q <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && req_seen) begin
                cmp_q <= compressed;
                m2m_q <= mem2mem;
                dir_q <= dev_to_mem;
            end
        end
    end

    dma_seq_next u_next (
        .cur      (state),
        .req_seen (req_seen),
        .hold_ack (hold_ack),
        .ready    (ready),
        .cmp_mode (cmp_q),
        .m2m_mode (m2m_q),
        .end_svc  (end_svc),
        .nxt      (state_nxt)
    );

    dma_seq_decode u_dec (
        .cur      (state),
        .cmp_mode (cmp_q),
        .dir_mode (dir_q),
        .hold_req (hold_req),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr)
    );

    assign state_code = state;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               hold_ack,
    input logic               ready,
    input logic               end_svc,
    input logic               hold_req,
    input logic [STATE_W-1:0] state_code,
    input logic               io_rd,
    input logic               io_wr,
    input logic               mem_rd,
    input logic               mem_wr
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_code == ST_IDLE && !hold_req));

    a_r3_s0_wait: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_S0 && !hold_ack) |=> state_code == ST_S0);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_IDLE) |-> !hold_req);

    a_r4_wait_stay: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_SW && !ready) |=> state_code == ST_SW);

    a_r6_pair: assert property (@(posedge clk) disable iff (rst)
        ($countones({io_rd, io_wr, mem_rd, mem_wr}) == 0) ||
        ($countones({io_rd, io_wr, mem_rd, mem_wr}) == 2) ||
        (state_code >= ST_M11));

    a_r6_quiet_early: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_IDLE || state_code == ST_S0 || state_code == ST_S1)
        |-> !(io_rd || io_wr || mem_rd || mem_wr));

    a_r7_no_io: assert property (@(posedge clk) disable iff (rst)
        (state_code >= ST_M11) |-> !(io_rd || io_wr));

    a_r7_ready_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_M13) |=> state_code == ST_M14);

    a_r8_end_s4: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_S4 && end_svc) |=> state_code == ST_IDLE);

endmodule

bind dma_cycle_seq dma_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_ack   (hold_ack),
    .ready      (ready),
    .end_svc    (end_svc),
    .hold_req   (hold_req),
    .state_code (state_code),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr)
);

// File: tb/tb_dma_cycle_seq.sv
`timescale 1ns/1ps
module tb_dma_cycle_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       svc_req = 1'b0, hold_ack = 1'b0, ready = 1'b1;
    logic       compressed = 1'b0, mem2mem = 1'b0, dev_to_mem = 1'b0, end_svc = 1'b0;
    logic       hold_req, io_rd, io_wr, mem_rd, mem_wr;
    logic [3:0] state_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dma_cycle_seq dut (
        .clk(clk), .rst(rst), .svc_req(svc_req), .hold_ack(hold_ack),
        .ready(ready), .compressed(compressed), .mem2mem(mem2mem),
        .dev_to_mem(dev_to_mem), .end_svc(end_svc), .hold_req(hold_req),
        .state_code(state_code), .io_rd(io_rd), .io_wr(io_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    // row: {req,ack,rdy,cmp,m2m,dir,eos, state[3:0], hreq, {io_rd,io_wr,mem_rd,mem_wr}}
    localparam int NV = 28;
    localparam logic [15:0] VEC [NV] = '{
        // normal timing, device to memory, one wait (R2 R3 R4 R6 R8 R10)
        {7'b1010010, 4'd1,  1'b1, 4'b0000},
        {7'b0010010, 4'd1,  1'b1, 4'b0000},
        {7'b0110010, 4'd2,  1'b1, 4'b0000},
        {7'b0110010, 4'd3,  1'b1, 4'b1001},
        {7'b0100010, 4'd4,  1'b1, 4'b1001},
        {7'b0100010, 4'd5,  1'b1, 4'b1001},
        {7'b0110010, 4'd6,  1'b1, 4'b1001},
        {7'b0110011, 4'd0,  1'b0, 4'b0000},
        {7'b0010000, 4'd0,  1'b0, 4'b0000},
        // compressed, memory to device; cmp input dropped mid-service (R5 R6 R8 R9)
        {7'b1111000, 4'd1,  1'b1, 4'b0000},
        {7'b0111000, 4'd2,  1'b1, 4'b0000},
        {7'b0111000, 4'd3,  1'b1, 4'b0110},
        {7'b0111000, 4'd6,  1'b1, 4'b0000},
        {7'b0110000, 4'd2,  1'b1, 4'b0000},
        {7'b0110000, 4'd3,  1'b1, 4'b0110},
        {7'b0100000, 4'd5,  1'b1, 4'b0110},
        {7'b0110000, 4'd6,  1'b1, 4'b0000},
        {7'b0110001, 4'd0,  1'b0, 4'b0000},
        // memory to memory, ready low, early end_svc (R7 R8)
        {7'b1000100, 4'd1,  1'b1, 4'b0000},
        {7'b0100100, 4'd7,  1'b1, 4'b0000},
        {7'b0100100, 4'd8,  1'b1, 4'b0010},
        {7'b0100100, 4'd9,  1'b1, 4'b0010},
        {7'b0100100, 4'd10, 1'b1, 4'b0000},
        {7'b0100100, 4'd11, 1'b1, 4'b0000},
        {7'b0100100, 4'd12, 1'b1, 4'b0001},
        {7'b0100100, 4'd13, 1'b1, 4'b0001},
        {7'b0100101, 4'd14, 1'b1, 4'b0000},
        {7'b0100100, 4'd7,  1'b1, 4'b0000}
    };

    task automatic check_out(input string tag, input logic [3:0] st,
                             input logic hr, input logic [3:0] sb);
        logic [8:0] got, exp;
        got = {state_code, hold_req, io_rd, io_wr, mem_rd, mem_wr};
        exp = {st, hr, sb};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got state=%0d hreq=%b stb=%b, expected state=%0d hreq=%b stb=%b",
                     tag, got[8:5], got[4], got[3:0], exp[8:5], exp[4], exp[3:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check_out("R1 reset state", 4'd0, 1'b0, 4'b0000);
        #1 rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {svc_req, hold_ack, ready, compressed, mem2mem, dev_to_mem, end_svc} = VEC[i][15:9];
            @(posedge clk);
            #1 check_out($sformatf("R2-table row %0d (R3 R4 R5 R6 R7 R8 R9 R10)", i),
                         VEC[i][8:5], VEC[i][4], VEC[i][3:0]);
            #1;
        end

        // R1: reset in mid-service
        rst = 1'b1;
        {svc_req, hold_ack, ready, compressed, mem2mem, dev_to_mem, end_svc} = 7'b0;
        @(posedge clk);
        #1 check_out("R1 mid-service reset", 4'd0, 1'b0, 4'b0000);
        #1 rst = 1'b0;
        @(posedge clk);
        #1 check_out("R3 idle after reset, no hold", 4'd0, 1'b0, 4'b0000);

        // R2: a pulse confined between rising edge and falling edge is not seen
        #1 svc_req = 1'b1;
        #1 svc_req = 1'b0;
        @(posedge clk);
        #1 check_out("R2 short pulse missed", 4'd0, 1'b0, 4'b0000);

        // R2: a pulse spanning the falling edge starts a service
        #1 svc_req = 1'b1;
        #4 svc_req = 1'b0;
        @(posedge clk);
        #1 check_out("R2 pulse across falling edge", 4'd1, 1'b1, 4'b0000);

        // R3: S0 holds for several cycles without acknowledge
        repeat (3) @(posedge clk);
        #1 check_out("R3 S0 held without ack", 4'd1, 1'b1, 4'b0000);

        finish_run();
    end

endmodule